// File: doc/BRIEF.md
# Serial Bank Window Register

This block holds the 9-bit bank number that picks which 32 KB slice of a 24-bit main address space a secondary processor reaches through the upper half of its own 16-bit address space. The main bus loads the number one bit per write. Each write to the bank port moves the register one place toward the least significant end. Bit 0 of the write data enters at the top, and the bit that leaves the bottom is lost. After nine such writes the register holds a complete, freshly loaded bank number.

A secondary-processor address in the range 0x8000 to 0xFFFF maps to a main address. The bank number forms the upper nine bits of that address, and the low fifteen bits of the secondary address form the rest. The block produces this translated address and a hit flag. Moving the translated access onto the main bus is left to the surrounding logic.

Top module: `bank_window`

## Requirements
- R1: While rst_ni is low and after its release, bank_o is 0, bank_valid_o is 0, and the translated address uses bank 0.
- R2: A write is taken as a bank load when wr_en_i is 1 and (wr_addr_i AND 0xFF7F00) equals 0xA06000. This covers 0xA06000 to 0xA060FF and the mirror at 0xA0E000 to 0xA0E0FF.
- R3: A write whose address does not match the decode in R2, or a cycle with wr_en_i low, leaves bank_o unchanged.
- R4: On a bank load, the new bank_o equals {wr_bit_i, old bank_o[8:1]}. The old bank_o[0] is discarded.
- R5: bank_valid_o rises one cycle after the ninth bank load since reset and then stays high. The load count saturates at 15.
- R6: xlat_addr_o equals {bank_o, sec_addr_i[14:0]}, and xlat_hit_o equals sec_addr_i[15].
- R7: When a bank load and a translation fall in the same cycle, the translation uses the bank value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Main-bus write strobe |
| wr_addr_i | input | 24 | Main-bus write address |
| wr_bit_i | input | 1 | Bit 0 of the write data |
| sec_addr_i | input | 16 | Secondary-processor address |
| bank_o | output | 9 | Current bank number |
| bank_valid_o | output | 1 | High once nine loads have occurred since reset |
| xlat_hit_o | output | 1 | Secondary address falls in the window |
| xlat_addr_o | output | 24 | Translated main address |

## Verification
The assertions assume that wr_en_i, wr_addr_i and wr_bit_i are stable and known at each rising clock edge. They make no assumption about how writes are spaced, and back-to-back loads are legal. The bench changes its inputs only on falling edges. It mixes decoded addresses, mirrored addresses and near-miss addresses with idle cycles, and it drives secondary addresses on both sides of 0x8000, including addresses that change in a cycle with a load.

// File: rtl/bank_window_pkg.sv
package bank_window_pkg;
  localparam int unsigned BANK_W = 9;
  localparam int unsigned MAIN_AW = 24;
  localparam int unsigned SEC_AW = 16;
  localparam int unsigned OFS_W = MAIN_AW - BANK_W;
  localparam logic [MAIN_AW-1:0] PORT_MASK = 24'hFF7F00;
  localparam logic [MAIN_AW-1:0] PORT_MATCH = 24'hA06000;
endpackage

// File: rtl/bank_port_decode.sv
module bank_port_decode
  import bank_window_pkg::*;
(
  input  logic               wr_en_i,
  input  logic [MAIN_AW-1:0] wr_addr_i,
  output logic               load_o
);
  always_comb load_o = wr_en_i && ((wr_addr_i & PORT_MASK) == PORT_MATCH);
endmodule

// File: rtl/bank_shift_reg.sv
module bank_shift_reg #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         bit_i,
  output logic [W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_o <= '0;
    else if (load_i) bank_o <= {bit_i, bank_o[W-1:1]};
  end

  a_r4_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> bank_o == {$past(bit_i), $past(bank_o[W-1:1])});
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(bank_o));
endmodule

// File: rtl/bank_fill_cnt.sv
module bank_fill_cnt #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned FILL = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic full_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_FILL = CNT_W'(FILL);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  always_comb full_o = cnt_q >= CNT_FILL;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> full_o);
  a_r5_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cnt_q));
endmodule

// File: rtl/bank_window.sv
module bank_window
  import bank_window_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [MAIN_AW-1:0] wr_addr_i,
  input  logic               wr_bit_i,
  input  logic [SEC_AW-1:0]  sec_addr_i,
  output logic [BANK_W-1:0]  bank_o,
  output logic               bank_valid_o,
  output logic               xlat_hit_o,
  output logic [MAIN_AW-1:0] xlat_addr_o
);
  logic load;

  bank_port_decode u_dec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .load_o   (load)
  );

  bank_shift_reg #(.W(BANK_W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .bit_i (wr_bit_i),
    .bank_o(bank_o)
  );

  bank_fill_cnt #(.CNT_W(4), .FILL(BANK_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .full_o(bank_valid_o)
  );

  // translation reads the registered bank, so a same-cycle load is not seen
  always_comb begin
    xlat_hit_o  = sec_addr_i[SEC_AW-1];
    xlat_addr_o = {bank_o, sec_addr_i[OFS_W-1:0]};
  end

  a_r6_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xlat_addr_o[MAIN_AW-1:OFS_W] == bank_o);
  a_r7_prewrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> $past(xlat_addr_o[MAIN_AW-1:OFS_W]) == $past(bank_o));
  a_r1_reset_valid: assert property (@(posedge clk_i)
    !rst_ni |-> !bank_valid_o && bank_o == '0);
endmodule

// File: tb/tb_bank_window.sv
module tb_bank_window;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        wr_en_i = 0;
  logic [23:0] wr_addr_i = '0;
  logic        wr_bit_i = 0;
  logic [15:0] sec_addr_i = '0;
  logic [8:0]  bank_o;
  logic        bank_valid_o;
  logic        xlat_hit_o;
  logic [23:0] xlat_addr_o;

  int total = 0;
  int bad = 0;
  int m_bank = 0;
  int m_loads = 0;

  always #10 clk_i = ~clk_i;

  bank_window dut (.*);

  function automatic bit dec_hit(input logic [23:0] a);
    return (a & 24'hFF7F00) == 24'hA06000;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    chk({req, " bank"}, int'(bank_o), m_bank);
    chk({req, " valid"}, int'(bank_valid_o), (m_loads >= 9) ? 1 : 0);
    chk({req, " hit"}, int'(xlat_hit_o), int'(sec_addr_i[15]));
    chk({req, " xlat"}, int'(xlat_addr_o), (m_bank << 15) | int'(sec_addr_i[14:0]));
  endtask

  // drive at falling edge, check pre-edge outputs, update model at rising edge
  task automatic step(input string req, input bit en, input logic [23:0] a,
                      input bit b, input logic [15:0] sa);
    wr_en_i = en; wr_addr_i = a; wr_bit_i = b; sec_addr_i = sa;
    #1;
    check_outputs(req);
    @(posedge clk_i);
    if (en && dec_hit(a)) begin
      m_bank = (m_bank >> 1) | (int'(b) << 8);
      if (m_loads < 15) m_loads++;
    end
    @(negedge clk_i);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    sec_addr_i = 16'hFFFF;
    #1 check_outputs("R1 in_reset");
    @(negedge clk_i);
    rst_ni = 1;
    step("R1 after_release", 0, 24'h0, 0, 16'h8123);

    // R4: load 1,0,1,1,0,0,1,0,1 and watch the bits shift down
    step("R4 load", 1, 24'hA06000, 1, 16'h8000);
    step("R4 load", 1, 24'hA06001, 0, 16'h1234);
    step("R2 mirror", 1, 24'hA0E0FF, 1, 16'hC000);
    step("R3 miss_a06100", 1, 24'hA06100, 1, 16'h8001);
    step("R3 miss_a07000", 1, 24'hA07000, 1, 16'h8002);
    step("R3 miss_a16000", 1, 24'hA16000, 0, 16'h8003);
    step("R3 no_en", 0, 24'hA06000, 1, 16'h8004);
    step("R4 load", 1, 24'hA06080, 1, 16'hFFFF);
    step("R4 load", 1, 24'hA06002, 0, 16'h7FFF);
    step("R7 same_cycle", 1, 24'hA06003, 0, 16'h9ABC);
    step("R7 same_cycle", 1, 24'hA0E010, 1, 16'hABCD);
    step("R5 eighth", 1, 24'hA06004, 0, 16'h8000);
    step("R5 not_yet", 0, 24'h0, 0, 16'h8000);
    step("R5 ninth", 1, 24'hA06005, 1, 16'hF00F);
    step("R5 valid", 0, 24'h0, 0, 16'h8765);

    // R4: drop old bit 0 by pushing 9 more ones, then zeros
    for (int i = 0; i < 9; i++) step("R4 all_ones", 1, 24'hA06000, 1, 16'h8000 | 16'(i));
    step("R6 full_bank", 0, 24'h0, 0, 16'hFFFF);
    for (int i = 0; i < 5; i++) step("R5 saturate", 1, 24'hA0E000, 0, 16'(i * 16'h1357));
    step("R5 sticky", 0, 24'h0, 0, 16'h0042);

    // R1: reset again mid-run
    rst_ni = 0;
    m_bank = 0; m_loads = 0;
    #1 check_outputs("R1 second_reset");
    @(negedge clk_i);
    rst_ni = 1;
    step("R1 released", 0, 24'h0, 0, 16'hBEEF);
    step("R6 low_half", 0, 24'h0, 0, 16'h0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule